// File: doc/BRIEF.md
# Reconfigurable-Operation Decode and Residency Tracker

This block sits beside the decode stage of a processor that has a reconfigurable array as one of its functional units. Custom array instructions name no source registers; they carry only an operation number and a destination register. The tracker recognises these instructions, looks the operation number up in a table of configurations currently resident in the array, and on a hit returns the 32-bit vector of source registers stored for that configuration, so the scheduler can build dependences. Each resident entry also records how many array rows its configuration occupies.

When the operation is not resident, the tracker raises a load trap naming the operation and stalls decode. Fetching the configuration bits is done elsewhere. When the loader finishes, it hands back the record header: the source vector and the row count. The tracker then evicts least-recently-used entries, one per cycle, until the new configuration fits in the array's rows. It installs the new entry and reports the trapped instruction as a hit. Independently, every store address is compared against the configuration address window. A store inside the window raises an exception and invalidates the whole table, so that the array can be flushed and reloaded.

The control is a four-state machine. RUN is the normal state. TRAP lasts one cycle and drives the trap. WAIT_LOAD holds until the load completes. MAKE_ROOM evicts or installs. The transitions are:
- RUN to TRAP on a miss.
- TRAP to WAIT_LOAD always.
- WAIT_LOAD to MAKE_ROOM on load completion.
- MAKE_ROOM to itself while an eviction is needed.
- MAKE_ROOM to RUN on install, or on abandon.
- Any state to RUN on a configuration-space store.

Top module: `rop_tracker`

## Requirements
- R1: The instruction word splits into operation code in bits [31:22], destination register in bits [21:17] and operation number in bits [16:0]. Only words whose code equals the parameter OPCODE (default 10'h3C1) are acted on; any other word causes no hit and no trap.
- R2: A matching instruction whose operation number is resident gives, one cycle later, op_hit high for one cycle. With it come op_dest equal to the instruction's destination field and op_srcvec equal to the vector stored for that operation. The hit causes no stall and no trap.
- R3: A matching instruction that is not resident gives, one cycle later, load_trap high for exactly one cycle, with load_op_id equal to its operation number. op_stall is high from that cycle on.
- R4: While op_stall is high, instruction inputs are ignored. The block stays stalled in WAIT_LOAD until load_done is sampled high, and load_done outside WAIT_LOAD has no effect.
- R5: The cycle after load_done is sampled, the block is in MAKE_ROOM. If the new row count fits beside the resident rows and an entry is free, the next edge installs it. op_hit for the trapped instruction appears, with its destination and the loaded source vector, and op_stall drops in the same cycle.
- R6: The rows of all resident configurations never sum above ARRAY_ROWS (default 32). At most ENTRIES (default 32) configurations are resident at once.
- R7: When the new configuration does not fit, one entry is evicted per cycle. The entry evicted is the one least recently installed or hit. Evictions continue until the new configuration fits, and evicted operations miss afterwards.
- R8: If the table is empty and the row count still exceeds ARRAY_ROWS, the request is abandoned on the next edge: op_stall drops, and no hit is reported.
- R9: A store whose address lies within CFG_BASE..CFG_LAST, inclusive, gives cfg_exc high the next cycle and leaves no operation resident. A store outside the window has no effect.
- R10: A configuration-space store in the same cycle as a matching instruction wins: no hit and no trap result from that instruction.
- R11: A configuration-space store while a miss is pending aborts it. This includes the install cycle. The block returns to RUN with no hit, and nothing is installed.
- R12: After reset, op_hit, load_trap, op_stall and cfg_exc are low, and every operation misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word present |
| insn_word | input | 32 | Instruction word |
| op_hit | output | 1 | Resident operation reported |
| op_dest | output | 5 | Destination register of the reported operation |
| op_srcvec | output | 32 | Source-register vector of the reported operation |
| op_stall | output | 1 | Decode stall |
| load_trap | output | 1 | One-cycle request to load a configuration |
| load_op_id | output | 17 | Operation number to load |
| load_done | input | 1 | Configuration load finished |
| load_srcvec | input | 32 | Source vector from the loaded record header |
| load_rows | input | 6 | Row count from the loaded record header |
| st_valid | input | 1 | Store observed |
| st_addr | input | 32 | Store address |
| cfg_exc | output | 1 | Configuration-space write exception |

## Verification
A configuration-space store can coincide with a lookup of a resident operation, and it can also coincide with the install cycle that ends a miss. The bench provokes the first by driving a hitting instruction and an in-window store on the same edge. It provokes the second by driving the store exactly in the cycle after load_done, when the block sits in MAKE_ROOM and would otherwise install. In both cases it expects cfg_exc and no op_hit. It then expects the same operation to miss again, which shows that neither the old entry nor the new one survived.

// File: rtl/rop_pkg.sv
package rop_pkg;

    localparam int INSN_W = 32;
    localparam int OPC_W  = 10;
    localparam int RD_W   = 5;
    localparam int OPID_W = 17;
    localparam int VEC_W  = 32;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RD_W-1:0]   rd;
        logic [OPID_W-1:0] id;
    } rop_insn_t;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_TRAP      = 2'd1,
        ST_WAIT_LOAD = 2'd2,
        ST_MAKE_ROOM = 2'd3
    } rop_state_e;

endpackage

// File: rtl/rop_insn_decode.sv
module rop_insn_decode
    import rop_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPCODE = 10'h3C1
) (
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn_word,
    output logic              is_rop,
    output logic [RD_W-1:0]   rd,
    output logic [OPID_W-1:0] id
);
    rop_insn_t fields;

    always_comb begin
        fields = rop_insn_t'(insn_word);
        is_rop = insn_valid && (fields.opc == OPCODE);
        rd     = fields.rd;
        id     = fields.id;
    end
endmodule

// File: rtl/rop_cfg_snoop.sv
module rop_cfg_snoop #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] CFG_BASE = 32'h0001_0000,
    parameter logic [31:0] CFG_LAST = 32'h0001_FFFF
) (
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              cfg_hit
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(CFG_LAST);

    always_comb begin
        cfg_hit = st_valid && (st_addr >= LO) && (st_addr <= HI);
    end
endmodule

// File: rtl/rop_entry_table.sv
module rop_entry_table #(
    parameter int ENTRIES    = 32,
    parameter int ARRAY_ROWS = 32,
    parameter int OPID_W     = 17,
    parameter int VEC_W      = 32,
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int ROW_W     = $clog2(ARRAY_ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPID_W-1:0] lk_id,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [VEC_W-1:0]  lk_vec,
    input  logic              acc_en,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic              ins_en,
    input  logic [OPID_W-1:0] ins_id,
    input  logic [VEC_W-1:0]  ins_vec,
    input  logic [ROW_W-1:0]  ins_rows,
    input  logic              ev_en,
    input  logic              flush,
    output logic              free_ok,
    output logic              any_valid,
    output logic [ROW_W-1:0]  rows_used
);
    logic [ENTRIES-1:0] valid_q;
    logic [OPID_W-1:0]  id_q   [ENTRIES];
    logic [VEC_W-1:0]   vec_q  [ENTRIES];
    logic [ROW_W-1:0]   rows_q [ENTRIES];
    logic [IDX_W-1:0]   age_q  [ENTRIES];
    logic [ROW_W-1:0]   rows_used_q;

    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   lru_idx;
    logic [IDX_W-1:0]   lru_age;

    // lookup: match lines per entry
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_match
            assign match[g] = valid_q[g] && (id_q[g] == lk_id);
        end
    endgenerate

    always_comb begin
        lk_hit = |match;
        lk_idx = '0;
        lk_vec = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_idx = IDX_W'(i);
                lk_vec = vec_q[i];
            end
        end
    end

    // lowest free slot
    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // oldest valid entry
    always_comb begin
        any_valid = 1'b0;
        lru_idx   = '0;
        lru_age   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (valid_q[i] && (!any_valid || age_q[i] > lru_age)) begin
                any_valid = 1'b1;
                lru_idx   = IDX_W'(i);
                lru_age   = age_q[i];
            end
        end
    end

    assign rows_used = rows_used_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q     <= '0;
            rows_used_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                id_q[i]   <= '0;
                vec_q[i]  <= '0;
                rows_q[i] <= '0;
                age_q[i]  <= '0;
            end
        end else if (flush) begin
            valid_q     <= '0;
            rows_used_q <= '0;
        end else begin
            if (acc_en) begin
                for (int j = 0; j < ENTRIES; j++) begin
                    if (valid_q[j] && (age_q[j] < age_q[acc_idx])) begin
                        age_q[j] <= age_q[j] + 1'b1;
                    end
                end
                age_q[acc_idx] <= '0;
            end
            if (ins_en) begin
                for (int j = 0; j < ENTRIES; j++) begin
                    if (valid_q[j]) begin
                        age_q[j] <= age_q[j] + 1'b1;
                    end
                end
                valid_q[free_idx] <= 1'b1;
                id_q[free_idx]    <= ins_id;
                vec_q[free_idx]   <= ins_vec;
                rows_q[free_idx]  <= ins_rows;
                age_q[free_idx]   <= '0;
                rows_used_q       <= rows_used_q + ins_rows;
            end
            if (ev_en) begin
                valid_q[lru_idx] <= 1'b0;
                rows_used_q      <= rows_used_q - rows_q[lru_idx];
            end
        end
    end

    // R6
    rows_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rows_used_q <= ROW_W'(ARRAY_ROWS));

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R6
    install_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> (free_ok && (({1'b0, rows_used_q} + {1'b0, ins_rows}) <= (ROW_W+1)'(ARRAY_ROWS))));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0 && rows_used_q == '0));

    // R7
    evict_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_en |-> any_valid);
endmodule

// File: rtl/rop_tracker.sv
module rop_tracker
    import rop_pkg::*;
#(
    parameter int                ENTRIES    = 32,
    parameter int                ARRAY_ROWS = 32,
    parameter logic [OPC_W-1:0]  OPCODE     = 10'h3C1,
    parameter logic [31:0]       CFG_BASE   = 32'h0001_0000,
    parameter logic [31:0]       CFG_LAST   = 32'h0001_FFFF,
    localparam int               ROW_W      = $clog2(ARRAY_ROWS + 1),
    localparam int               IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn_word,
    output logic              op_hit,
    output logic [RD_W-1:0]   op_dest,
    output logic [VEC_W-1:0]  op_srcvec,
    output logic              op_stall,
    output logic              load_trap,
    output logic [OPID_W-1:0] load_op_id,
    input  logic              load_done,
    input  logic [VEC_W-1:0]  load_srcvec,
    input  logic [ROW_W-1:0]  load_rows,
    input  logic              st_valid,
    input  logic [31:0]       st_addr,
    output logic              cfg_exc
);
    rop_state_e state_q, state_d;

    logic              dec_rop;
    logic [RD_W-1:0]   dec_rd;
    logic [OPID_W-1:0] dec_id;
    logic              cfg_hit;

    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [VEC_W-1:0]  lk_vec;
    logic              free_ok;
    logic              any_valid;
    logic [ROW_W-1:0]  rows_used;

    logic [OPID_W-1:0] pend_id_q;
    logic [RD_W-1:0]   pend_rd_q;
    logic [VEC_W-1:0]  pend_vec_q;
    logic [ROW_W-1:0]  pend_rows_q;

    logic running, fits, acc_en, ins_en, ev_en, miss_now;

    rop_insn_decode #(.OPCODE(OPCODE)) u_dec (
        .insn_valid (insn_valid),
        .insn_word  (insn_word),
        .is_rop     (dec_rop),
        .rd         (dec_rd),
        .id         (dec_id)
    );

    rop_cfg_snoop #(.ADDR_W(32), .CFG_BASE(CFG_BASE), .CFG_LAST(CFG_LAST)) u_snoop (
        .st_valid (st_valid),
        .st_addr  (st_addr),
        .cfg_hit  (cfg_hit)
    );

    rop_entry_table #(
        .ENTRIES    (ENTRIES),
        .ARRAY_ROWS (ARRAY_ROWS),
        .OPID_W     (OPID_W),
        .VEC_W      (VEC_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_id     (dec_id),
        .lk_hit    (lk_hit),
        .lk_idx    (lk_idx),
        .lk_vec    (lk_vec),
        .acc_en    (acc_en),
        .acc_idx   (lk_idx),
        .ins_en    (ins_en),
        .ins_id    (pend_id_q),
        .ins_vec   (pend_vec_q),
        .ins_rows  (pend_rows_q),
        .ev_en     (ev_en),
        .flush     (cfg_hit),
        .free_ok   (free_ok),
        .any_valid (any_valid),
        .rows_used (rows_used)
    );

    // table control and next state
    always_comb begin
        running  = (state_q == ST_RUN);
        fits     = free_ok &&
                   (({1'b0, rows_used} + {1'b0, pend_rows_q}) <= (ROW_W+1)'(ARRAY_ROWS));
        acc_en   = running && dec_rop && lk_hit && !cfg_hit;
        miss_now = running && dec_rop && !lk_hit && !cfg_hit;
        ins_en   = (state_q == ST_MAKE_ROOM) && fits && !cfg_hit;
        ev_en    = (state_q == ST_MAKE_ROOM) && !fits && any_valid && !cfg_hit;

        state_d = state_q;
        if (cfg_hit) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN:       if (miss_now) state_d = ST_TRAP;
                ST_TRAP:      state_d = ST_WAIT_LOAD;
                ST_WAIT_LOAD: if (load_done) state_d = ST_MAKE_ROOM;
                ST_MAKE_ROOM: if (fits || !any_valid) state_d = ST_RUN;
                default:      state_d = ST_RUN;
            endcase
        end
    end

    // state register and pending request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            pend_id_q   <= '0;
            pend_rd_q   <= '0;
            pend_vec_q  <= '0;
            pend_rows_q <= '0;
        end else begin
            state_q <= state_d;
            if (miss_now) begin
                pend_id_q <= dec_id;
                pend_rd_q <= dec_rd;
            end
            if (state_q == ST_WAIT_LOAD && load_done) begin
                pend_vec_q  <= load_srcvec;
                pend_rows_q <= load_rows;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_hit    <= 1'b0;
            op_dest   <= '0;
            op_srcvec <= '0;
            cfg_exc   <= 1'b0;
        end else begin
            op_hit  <= acc_en || ins_en;
            cfg_exc <= cfg_hit;
            if (acc_en) begin
                op_dest   <= dec_rd;
                op_srcvec <= lk_vec;
            end else if (ins_en) begin
                op_dest   <= pend_rd_q;
                op_srcvec <= pend_vec_q;
            end
        end
    end

    assign op_stall   = (state_q != ST_RUN);
    assign load_trap  = (state_q == ST_TRAP);
    assign load_op_id = pend_id_q;

    // R2
    hit_unstalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_hit |-> !op_stall);

    // R3
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_trap |=> !load_trap);

    // R3
    miss_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dec_rop && !lk_hit && !cfg_hit) |=> (load_trap && op_stall));

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_LOAD && !load_done && !cfg_hit) |=> (state_q == ST_WAIT_LOAD));

    // R10
    exc_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_exc |-> !op_hit);

    // R11
    exc_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_exc |-> !op_stall);
endmodule

// File: tb/rop_tracker_tb.sv
`timescale 1ns/1ps
module rop_tracker_tb;
    localparam logic [9:0] OPC = 10'h3C1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        op_hit;
    logic [4:0]  op_dest;
    logic [31:0] op_srcvec;
    logic        op_stall;
    logic        load_trap;
    logic [16:0] load_op_id;
    logic        load_done = 1'b0;
    logic [31:0] load_srcvec = '0;
    logic [5:0]  load_rows = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic        cfg_exc;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rop_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .op_hit(op_hit), .op_dest(op_dest), .op_srcvec(op_srcvec), .op_stall(op_stall),
        .load_trap(load_trap), .load_op_id(load_op_id), .load_done(load_done),
        .load_srcvec(load_srcvec), .load_rows(load_rows), .st_valid(st_valid),
        .st_addr(st_addr), .cfg_exc(cfg_exc)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rd, input logic [16:0] id);
        return {OPC, rd, id};
    endfunction

    // R2: resident operation reports a hit one cycle later
    task automatic t_hit(input logic [16:0] id, input logic [4:0] rd, input logic [31:0] vec);
        @(negedge clk); insn_valid = 1; insn_word = mk(rd, id);
        @(negedge clk); insn_valid = 0;
        chk(op_hit == 1, "R2 hit", 32'(op_hit), 1);
        chk(op_dest == rd, "R2 dest", 32'(op_dest), 32'(rd));
        chk(op_srcvec == vec, "R2 srcvec", op_srcvec, vec);
        chk(load_trap == 0 && op_stall == 0, "R2 no trap", {load_trap, op_stall}, 0);
    endtask

    // R3/R5/R7: miss, trap, load, nev evictions, install
    task automatic t_miss(input logic [16:0] id, input logic [4:0] rd, input logic [31:0] vec,
                          input logic [5:0] rows, input int nev);
        @(negedge clk); insn_valid = 1; insn_word = mk(rd, id);
        @(negedge clk); insn_valid = 0;
        chk(load_trap == 1, "R3 trap", 32'(load_trap), 1);
        chk(load_op_id == id, "R3 trap id", 32'(load_op_id), 32'(id));
        chk(op_stall == 1 && op_hit == 0, "R3 stall", {op_stall, op_hit}, 2);
        @(negedge clk);
        chk(load_trap == 0 && op_stall == 1, "R3 one-cycle trap", {load_trap, op_stall}, 1);
        load_done = 1; load_srcvec = vec; load_rows = rows;
        @(negedge clk); load_done = 0;
        chk(op_stall == 1 && op_hit == 0, "R5 make room", {op_stall, op_hit}, 2);
        for (int k = 0; k < nev; k++) begin
            @(negedge clk);
            chk(op_stall == 1 && op_hit == 0, "R7 evicting", {op_stall, op_hit}, 2);
        end
        @(negedge clk);
        chk(op_hit == 1 && op_stall == 0, "R5 install hit", {op_hit, op_stall}, 2);
        chk(op_dest == rd, "R5 dest", 32'(op_dest), 32'(rd));
        chk(op_srcvec == vec, "R5 srcvec", op_srcvec, vec);
    endtask

    // R12
    task automatic t_reset;
        chk(op_hit == 0 && load_trap == 0 && op_stall == 0 && cfg_exc == 0, "R12 reset",
            {op_hit, load_trap, op_stall, cfg_exc}, 0);
    endtask

    // R1: foreign code ignored
    task automatic t_foreign(input logic [16:0] id);
        @(negedge clk); insn_valid = 1; insn_word = {10'h3C0, 5'd3, id};
        @(negedge clk); insn_valid = 0;
        chk(op_hit == 0 && load_trap == 0 && op_stall == 0, "R1 foreign",
            {op_hit, load_trap, op_stall}, 0);
    endtask

    // R4: instructions during stall ignored, load_done outside wait ignored
    task automatic t_stall(input logic [16:0] id, input logic [16:0] res_id);
        @(negedge clk); load_done = 1; load_rows = 6'd1;
        @(negedge clk); load_done = 0;
        chk(op_hit == 0 && op_stall == 0, "R4 stray load_done", {op_hit, op_stall}, 0);
        insn_valid = 1; insn_word = mk(5'd9, id);
        @(negedge clk); insn_word = mk(5'd4, res_id);
        @(negedge clk);
        chk(op_hit == 0 && op_stall == 1, "R4 ignored in trap", {op_hit, op_stall}, 1);
        @(negedge clk); insn_valid = 0;
        chk(op_hit == 0 && op_stall == 1, "R4 ignored in wait", {op_hit, op_stall}, 1);
        repeat (3) @(negedge clk);
        chk(op_stall == 1 && load_trap == 0, "R4 wait holds", {op_stall, load_trap}, 2);
        load_done = 1; load_srcvec = 32'h0000_0606; load_rows = 6'd2;
        @(negedge clk); load_done = 0;
        @(negedge clk);
        chk(op_hit == 1 && op_dest == 5'd9, "R4 resumed", {op_hit, 27'(op_dest)}, {1'b1, 27'd9});
    endtask

    // R8
    task automatic t_oversize(input logic [16:0] id, input int nres);
        @(negedge clk); insn_valid = 1; insn_word = mk(5'd1, id);
        @(negedge clk); insn_valid = 0;
        @(negedge clk); load_done = 1; load_rows = 6'd40; load_srcvec = 32'hFFFF;
        @(negedge clk); load_done = 0;
        for (int k = 0; k < nres; k++) begin
            @(negedge clk);
            chk(op_stall == 1 && op_hit == 0, "R8 evicting all", {op_stall, op_hit}, 2);
        end
        @(negedge clk);
        chk(op_stall == 0 && op_hit == 0, "R8 abandoned", {op_stall, op_hit}, 0);
    endtask

    // R9
    task automatic t_store(input logic [31:0] addr, input bit exp_exc);
        @(negedge clk); st_valid = 1; st_addr = addr;
        @(negedge clk); st_valid = 0;
        chk(cfg_exc == exp_exc, "R9 exception", 32'(cfg_exc), 32'(exp_exc));
    endtask

    // R10
    task automatic t_store_with_hit(input logic [16:0] id);
        @(negedge clk); st_valid = 1; st_addr = 32'h0001_8000;
        insn_valid = 1; insn_word = mk(5'd2, id);
        @(negedge clk); st_valid = 0; insn_valid = 0;
        chk(cfg_exc == 1 && op_hit == 0 && load_trap == 0, "R10 store wins",
            {cfg_exc, op_hit, load_trap}, 4);
    endtask

    // R11
    task automatic t_store_at_install(input logic [16:0] id);
        @(negedge clk); insn_valid = 1; insn_word = mk(5'd8, id);
        @(negedge clk); insn_valid = 0;
        @(negedge clk); load_done = 1; load_rows = 6'd3; load_srcvec = 32'h0000_0101;
        @(negedge clk); load_done = 0; st_valid = 1; st_addr = 32'h0001_FFFF;
        @(negedge clk); st_valid = 0;
        chk(cfg_exc == 1 && op_hit == 0 && op_stall == 0, "R11 install aborted",
            {cfg_exc, op_hit, op_stall}, 4);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_miss(17'd5, 5'd10, 32'h0000_000C, 6'd10, 0);
        t_hit(17'd5, 5'd11, 32'h0000_000C);
        t_miss(17'd6, 5'd12, 32'h0000_0030, 6'd12, 0);
        t_miss(17'd7, 5'd13, 32'h0000_0300, 6'd8, 0);
        t_hit(17'd5, 5'd14, 32'h0000_000C);
        // R7: LRU is 6
        t_miss(17'd8, 5'd15, 32'h0000_3000, 6'd5, 1);
        t_hit(17'd7, 5'd16, 32'h0000_0300);
        // R7: 6 was evicted; LRU now 5
        t_miss(17'd6, 5'd17, 32'h0000_0031, 6'd12, 1);
        // R6/R7: full-array record evicts 8, 7, 6
        t_miss(17'd5, 5'd18, 32'h0000_0001, 6'd32, 3);
        t_hit(17'd5, 5'd19, 32'h0000_0001);
        t_miss(17'd7, 5'd20, 32'h0000_0002, 6'd1, 1);
        t_stall(17'd9, 17'd7);
        t_oversize(17'd10, 2);
        t_miss(17'd9, 5'd21, 32'h0000_0909, 6'd2, 0);
        t_foreign(17'd9);
        t_store(32'h0002_0000, 0);
        t_store(32'h0000_FFFF, 0);
        t_hit(17'd9, 5'd22, 32'h0000_0909);
        t_store(32'h0001_0000, 1);
        t_miss(17'd9, 5'd23, 32'h0000_0A0A, 6'd4, 0);
        t_store_with_hit(17'd9);
        t_store_at_install(17'd9);
        t_miss(17'd9, 5'd24, 32'h0000_0B0B, 6'd4, 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule